// File: doc/BRIEF.md
# Event-to-Counter Assignment Table

This block keeps the association between hardware performance events and the programmable counters that tally them. Software programs a counter's event selector. Each such write goes through a port here, which either installs the event in the table, removes every event bound to that counter, or refuses the write. Pipeline logic raises an event strobe carrying an event identifier. When the event is bound to a counter, the block answers with an increment strobe that names the counter. A side query port tells the counter logic whether a given counter index tracks clock cycles or retired instructions.

The table holds exactly one slot per supported event. Each slot has a valid flag and a counter index. The first binding of an event is kept: a later attempt to bind the same event to another counter reports success and changes nothing. Only five event identifiers are accepted, so the table cannot overflow. Write responses and increment strobes come out registered, one cycle after their request. The query outputs are combinational from the current table.

The event and write inputs are plain strobes with no back-pressure. Every asserted strobe is taken in the cycle it is presented, and the outputs carry no ready input. At most one write and one event can be presented per cycle.

Top module: `evt_ctr_map`

## Requirements
- R1: After reset every slot is empty. No write response and no increment strobe is raised. Counter indices other than 0 and 2 report neither cycles nor instructions.
- R2: A write is rejected when its counter index is below 3, is at or above NUM_CTRS (default 29), or has a clear bit in AVAIL_MASK (by default counter 11 is unavailable). A rejected write returns ok=0 and leaves the table unchanged, and this holds even when the written value is zero.
- R3: A write of the all-zero value to a valid counter returns ok=1 and empties every slot bound to that counter.
- R4: For a non-zero value, the event identifier is bits [19:0] of the written value. Bits above bit 19 have no effect on the identifier.
- R5: When the identifier's slot is already bound, the write returns ok=1 and the existing binding is kept.
- R6: The accepted identifiers are 0x00001 (cycles), 0x00002 (instructions), 0x10019 (data-TLB read miss), 0x1001B (data-TLB write miss) and 0x10021 (instruction-TLB prefetch miss). Any other non-zero value is rejected with ok=0.
- R7: An event strobe whose identifier has a bound slot raises inc_valid with that slot's counter index one cycle later. An unbound or unknown identifier produces no increment.
- R8: Query index 0 always reports cycles and query index 2 always reports instructions. Any other index reports cycles (or instructions) only while the 0x00001 (or 0x00002) slot is bound to that index.
- R9: An event and a write that touch the same slot in the same cycle see the old binding. The new binding applies from the next cycle.
- R10: wr_resp_valid is raised exactly one cycle after each cycle with wr_en high, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Event-selector write strobe |
| wr_ctr | input | 5 | Counter index being written |
| wr_val | input | 64 | Written selector value |
| wr_resp_valid | output | 1 | Write response present |
| wr_resp_ok | output | 1 | Write accepted (1) or rejected (0) |
| evt_valid | input | 1 | Event occurrence strobe |
| evt_id | input | 20 | Identifier of the occurring event |
| inc_valid | output | 1 | Increment request |
| inc_ctr | output | 5 | Counter to increment |
| query_ctr | input | 5 | Counter index being queried |
| query_is_cycles | output | 1 | Queried counter tracks cycles |
| query_is_instr | output | 1 | Queried counter tracks instructions |

## Verification
The assertions assume that wr_en and evt_valid are sampled once per rising edge, with wr_ctr, wr_val and evt_id known whenever their strobe is high. They also assume a clean synchronous reset. The stimulus changes inputs only on the falling edge and drops both strobes right after each rising edge, so every request lasts exactly one cycle. Back-to-back requests, same-cycle write-and-event collisions, and writes to illegal indices are placed deliberately rather than left to chance.

// File: rtl/ecm_pkg.sv
package ecm_pkg;
  localparam int EVT_W    = 20;
  localparam int NUM_EVT  = 5;
  localparam int SLOT_CYC = 0;
  localparam int SLOT_INS = 1;

  // identifier accepted in each table slot
  function automatic logic [EVT_W-1:0] evt_code(input int slot);
    case (slot)
      0:       return 20'h00001;
      1:       return 20'h00002;
      2:       return 20'h10019;
      3:       return 20'h1001B;
      4:       return 20'h10021;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/ecm_decode.sv
module ecm_decode
  import ecm_pkg::*;
(
  input  logic [EVT_W-1:0]   id,
  output logic [NUM_EVT-1:0] hit,
  output logic               any
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_cmp
    assign hit[i] = (id == evt_code(i));
  end
  assign any = |hit;
endmodule

// File: rtl/ecm_table.sv
module ecm_table
  import ecm_pkg::*;
#(
  parameter int CTR_W    = 5,
  parameter int NUM_CTRS = 29,
  parameter int VAL_W    = 64,
  parameter logic [(1<<CTR_W)-1:0] AVAIL_MASK = 32'hFFFF_F7F8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [CTR_W-1:0]                wr_ctr,
  input  logic [VAL_W-1:0]                wr_val,
  output logic                            resp_valid,
  output logic                            resp_ok,
  output logic [NUM_EVT-1:0]              map_vld,
  output logic [NUM_EVT-1:0][CTR_W-1:0]   map_ctr
);
  localparam logic [CTR_W-1:0] FIRST_PROG = CTR_W'(3);

  logic [NUM_EVT-1:0]            vld_q, vld_d;
  logic [NUM_EVT-1:0][CTR_W-1:0] ctr_q, ctr_d;
  logic [NUM_EVT-1:0]            hit;
  logic                          hit_any, ctr_ok, ok_d, is_zero;

  ecm_decode u_dec (.id(wr_val[EVT_W-1:0]), .hit(hit), .any(hit_any));

  assign is_zero = (wr_val == '0);
  assign ctr_ok  = (wr_ctr >= FIRST_PROG) && (int'(wr_ctr) < NUM_CTRS) && AVAIL_MASK[wr_ctr];

  always_comb begin
    vld_d = vld_q;
    ctr_d = ctr_q;
    ok_d  = 1'b0;
    if (wr_en && ctr_ok) begin
      if (is_zero) begin
        ok_d = 1'b1;
        for (int i = 0; i < NUM_EVT; i++)
          if (vld_q[i] && ctr_q[i] == wr_ctr) vld_d[i] = 1'b0;
      end else if (hit_any) begin
        ok_d = 1'b1;
        for (int i = 0; i < NUM_EVT; i++)
          if (hit[i] && !vld_q[i]) begin
            vld_d[i] = 1'b1;
            ctr_d[i] = wr_ctr;
          end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q      <= '0;
      ctr_q      <= '0;
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
    end else begin
      vld_q      <= vld_d;
      ctr_q      <= ctr_d;
      resp_valid <= wr_en;
      resp_ok    <= ok_d;
    end
  end

  assign map_vld = vld_q;
  assign map_ctr = ctr_q;

  // R2
  low_ctr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ctr < FIRST_PROG) |=> (!resp_ok && vld_q == $past(vld_q) && ctr_q == $past(ctr_q)));

  // R10
  resp_follows_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> resp_valid);

  // R10
  resp_only_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !resp_valid);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
    // R5
    binding_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[i] && !(wr_en && wr_val == '0)) |=> (vld_q[i] && ctr_q[i] == $past(ctr_q[i])));

    // R3
    zero_unbinds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_val == '0 && vld_q[i] && ctr_q[i] == wr_ctr) |=> !vld_q[i]);
  end
endmodule

// File: rtl/ecm_lookup.sv
module ecm_lookup
  import ecm_pkg::*;
#(
  parameter int CTR_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          evt_valid,
  input  logic [EVT_W-1:0]              evt_id,
  input  logic [NUM_EVT-1:0]            map_vld,
  input  logic [NUM_EVT-1:0][CTR_W-1:0] map_ctr,
  output logic                          inc_valid,
  output logic [CTR_W-1:0]              inc_ctr
);
  logic [NUM_EVT-1:0] hit, sel;
  logic               hit_any;
  logic [CTR_W-1:0]   ctr_d;

  ecm_decode u_dec (.id(evt_id), .hit(hit), .any(hit_any));

  assign sel = hit & map_vld;

  always_comb begin
    ctr_d = '0;
    for (int i = 0; i < NUM_EVT; i++)
      ctr_d = ctr_d | (map_ctr[i] & {CTR_W{sel[i]}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inc_valid <= 1'b0;
      inc_ctr   <= '0;
    end else begin
      inc_valid <= evt_valid && hit_any && (|sel);
      inc_ctr   <= ctr_d;
    end
  end

  // R7
  inc_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> !inc_valid);

  // R7
  inc_ctr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_valid |-> inc_ctr >= CTR_W'(3));
endmodule

// File: rtl/ecm_fixed_match.sv
module ecm_fixed_match
  import ecm_pkg::*;
#(
  parameter int CTR_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CTR_W-1:0]              query_ctr,
  input  logic [NUM_EVT-1:0]            map_vld,
  input  logic [NUM_EVT-1:0][CTR_W-1:0] map_ctr,
  output logic                          is_cycles,
  output logic                          is_instr
);
  localparam logic [CTR_W-1:0] FIXED_CYC = CTR_W'(0);
  localparam logic [CTR_W-1:0] FIXED_INS = CTR_W'(2);

  assign is_cycles = (query_ctr == FIXED_CYC) ||
                     (map_vld[SLOT_CYC] && map_ctr[SLOT_CYC] == query_ctr);
  assign is_instr  = (query_ctr == FIXED_INS) ||
                     (map_vld[SLOT_INS] && map_ctr[SLOT_INS] == query_ctr);

  // R8
  fixed_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (query_ctr == FIXED_CYC) |-> (is_cycles && !is_instr));

  // R8
  fixed_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (query_ctr == FIXED_INS) |-> (is_instr && !is_cycles));
endmodule

// File: rtl/evt_ctr_map.sv
module evt_ctr_map
  import ecm_pkg::*;
#(
  parameter int CTR_W    = 5,
  parameter int NUM_CTRS = 29,
  parameter int VAL_W    = 64,
  parameter logic [(1<<CTR_W)-1:0] AVAIL_MASK = 32'hFFFF_F7F8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CTR_W-1:0]   wr_ctr,
  input  logic [VAL_W-1:0]   wr_val,
  output logic               wr_resp_valid,
  output logic               wr_resp_ok,
  input  logic               evt_valid,
  input  logic [EVT_W-1:0]   evt_id,
  output logic               inc_valid,
  output logic [CTR_W-1:0]   inc_ctr,
  input  logic [CTR_W-1:0]   query_ctr,
  output logic               query_is_cycles,
  output logic               query_is_instr
);
  logic [NUM_EVT-1:0]            map_vld;
  logic [NUM_EVT-1:0][CTR_W-1:0] map_ctr;

  ecm_table #(.CTR_W(CTR_W), .NUM_CTRS(NUM_CTRS), .VAL_W(VAL_W), .AVAIL_MASK(AVAIL_MASK)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctr(wr_ctr), .wr_val(wr_val),
    .resp_valid(wr_resp_valid), .resp_ok(wr_resp_ok), .map_vld(map_vld), .map_ctr(map_ctr));

  ecm_lookup #(.CTR_W(CTR_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_id(evt_id),
    .map_vld(map_vld), .map_ctr(map_ctr), .inc_valid(inc_valid), .inc_ctr(inc_ctr));

  ecm_fixed_match #(.CTR_W(CTR_W)) u_fixed (
    .clk(clk), .rst_n(rst_n), .query_ctr(query_ctr), .map_vld(map_vld), .map_ctr(map_ctr),
    .is_cycles(query_is_cycles), .is_instr(query_is_instr));

  // R9
  new_binding_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !(|(map_vld & {NUM_EVT{1'b1}})) ) |=> !inc_valid);
endmodule

// File: tb/tb_evt_ctr_map.sv
module tb_evt_ctr_map;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_ctr = '0;
  logic [63:0] wr_val = '0;
  logic        wr_resp_valid, wr_resp_ok;
  logic        evt_valid = 1'b0;
  logic [19:0] evt_id = '0;
  logic        inc_valid;
  logic [4:0]  inc_ctr;
  logic [4:0]  query_ctr = 5'd1;
  logic        query_is_cycles, query_is_instr;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_ctr_map dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctr(wr_ctr), .wr_val(wr_val),
    .wr_resp_valid(wr_resp_valid), .wr_resp_ok(wr_resp_ok),
    .evt_valid(evt_valid), .evt_id(evt_id), .inc_valid(inc_valid), .inc_ctr(inc_ctr),
    .query_ctr(query_ctr), .query_is_cycles(query_is_cycles), .query_is_instr(query_is_instr));

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    bit         rv;
    bit         rok;
    bit         iv;
    logic [4:0] ic;
    int         tag;
  } exp_t;
  exp_t sb_q[$];

  // bench model of the table, built from the requirements
  logic [19:0] codes [5] = '{20'h00001, 20'h00002, 20'h10019, 20'h1001B, 20'h10021};
  bit          mv [5];
  logic [4:0]  mc [5];

  function automatic int slot_of(input logic [19:0] id);
    for (int i = 0; i < 5; i++) if (codes[i] == id) return i;
    return -1;
  endfunction

  function automatic bit ctr_legal(input logic [4:0] c);
    return (c >= 5'd3) && (c < 5'd29) && (c != 5'd11);
  endfunction

  task automatic chk(input bit cond, input int tag, input string what,
                     input longint act, input longint expv);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // driver: one cycle of stimulus, expectation pushed to the scoreboard
  task automatic step(input bit we, input logic [4:0] wc, input logic [63:0] wv,
                      input bit ev, input logic [19:0] eid, input int tag);
    exp_t e;
    int s;
    @(negedge clk);
    wr_en = we; wr_ctr = wc; wr_val = wv;
    evt_valid = ev; evt_id = eid;
    e.tag = tag; e.rv = we; e.rok = 1'b0; e.iv = 1'b0; e.ic = '0;
    if (ev) begin
      s = slot_of(eid);
      if (s >= 0 && mv[s]) begin e.iv = 1'b1; e.ic = mc[s]; end
    end
    if (we && ctr_legal(wc)) begin
      if (wv == 64'd0) begin
        e.rok = 1'b1;
        for (int i = 0; i < 5; i++) if (mv[i] && mc[i] == wc) mv[i] = 1'b0;
      end else begin
        s = slot_of(wv[19:0]);
        if (s >= 0) begin
          e.rok = 1'b1;
          if (!mv[s]) begin mv[s] = 1'b1; mc[s] = wc; end
        end
      end
    end
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    evt_valid = 1'b0;
    sb_q.push_back(e);
  endtask

  task automatic wr(input logic [4:0] c, input logic [63:0] v, input int tag);
    step(1'b1, c, v, 1'b0, '0, tag);
  endtask

  task automatic ev(input logic [19:0] id, input int tag);
    step(1'b0, '0, '0, 1'b1, id, tag);
  endtask

  task automatic qchk(input logic [4:0] c, input int tag);
    bit ec, ei;
    @(negedge clk);
    query_ctr = c;
    #1;
    ec = (c == 5'd0) || (mv[0] && mc[0] == c);
    ei = (c == 5'd2) || (mv[1] && mc[1] == c);
    chk(query_is_cycles == ec, tag, "query cycles", query_is_cycles, ec);
    chk(query_is_instr == ei, tag, "query instr", query_is_instr, ei);
  endtask

  // monitor: pops expectations as results appear
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (sb_q.size() > 0) begin
          e = sb_q.pop_front();
          chk(wr_resp_valid == e.rv, e.tag, "resp_valid", wr_resp_valid, e.rv);
          if (e.rv) chk(wr_resp_ok == e.rok, e.tag, "resp_ok", wr_resp_ok, e.rok);
          chk(inc_valid == e.iv, e.tag, "inc_valid", inc_valid, e.iv);
          if (e.iv) chk(inc_ctr == e.ic, e.tag, "inc_ctr", inc_ctr, e.ic);
        end else if (wr_resp_valid || inc_valid) begin
          chk(1'b0, 10, "unexpected output", {wr_resp_valid, inc_valid}, 0);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) begin mv[i] = 1'b0; mc[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk(!wr_resp_valid && !inc_valid, 1, "idle outputs after reset", {wr_resp_valid, inc_valid}, 0);
    qchk(5'd5, 1);
    qchk(5'd0, 8);   // R8 fixed cycles counter
    qchk(5'd2, 8);   // R8 fixed instructions counter
    ev(20'h00001, 1);
    // R2 illegal indices: below 3, unavailable 11, out of range 30
    wr(5'd1, 64'h1, 2);
    wr(5'd11, 64'h1, 2);
    wr(5'd30, 64'h2, 2);
    ev(20'h00001, 2);
    ev(20'h00002, 2);
    // R4 upper bits ignored in identifier
    wr(5'd5, 64'hABC0_0000_0000_0001, 4);
    ev(20'h00001, 4);
    qchk(5'd5, 8);
    // R5 first binding wins
    wr(5'd6, 64'h1, 5);
    ev(20'h00001, 5);
    // R6 whitelist
    wr(5'd7, 64'h10019, 6);
    wr(5'd7, 64'h1001B, 6);
    wr(5'd8, 64'h10020, 6);
    wr(5'd8, 64'h00003, 6);
    ev(20'h10020, 6);
    wr(5'd8, 64'h10021, 6);
    wr(5'd9, 64'h2, 6);
    // R7 back-to-back lookups
    ev(20'h1001B, 7);
    ev(20'h10019, 7);
    ev(20'h00002, 7);
    ev(20'h10021, 7);
    qchk(5'd9, 8);
    // R3 zero write unbinds every slot of counter 7
    wr(5'd7, 64'h0, 3);
    ev(20'h10019, 3);
    ev(20'h1001B, 3);
    ev(20'h10021, 3);
    // R9 same-cycle write and event see the old binding
    step(1'b1, 5'd12, 64'h10019, 1'b1, 20'h10019, 9);
    ev(20'h10019, 9);
    // R2 zero write to illegal counter changes nothing
    wr(5'd2, 64'h0, 2);
    ev(20'h00002, 2);
    // R3 then R8: unbinding cycles from counter 5
    wr(5'd5, 64'h0, 3);
    qchk(5'd5, 8);
    qchk(5'd0, 8);
    ev(20'h00001, 3);
    // R10 idle cycles raise no response
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, 10, "scoreboard drained", sb_q.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule